// File: doc/BRIEF.md
# Top-of-Memory Chip Select Decoder

This block watches a 20-bit physical address bus and drives an active-low select for a memory window that always ends at the top address, FFFFFh. The window size is held in a small size register. Software sets the window to 64 KB, 128 KB, 256 KB or 512 KB, and the window always starts at 100000h minus that size. The select is computed when a bus cycle starts and stays unchanged until the cycle ends.

The select leaves reset already asserted, with the size set to 64 KB (F0000h–FFFFFh). This lets the first code fetch after reset, at FFFF0h, reach the boot memory before any setup has run. While another master holds the bus, the select is forced inactive. When the bus is handed back, the select stays inactive until a new bus cycle starts.

Top module: `hi_region_sel`

## Requirements
- R1: While reset is applied and after it is released, `win_sel_n` is low (active) and the size code is 00 (64 KB window, F0000h–FFFFFh). It stays low until the first cycle start, bus-hold or cycle end.
- R2: The 2-bit size code maps as 00=64 KB, 01=128 KB, 10=256 KB, 11=512 KB. The window spans from 100000h minus that size up to FFFFFh.
- R3: When `cyc_start` is high and `bus_hold` is low, `win_sel_n` one clock later is low if `bus_addr` lies inside the window and high otherwise.
- R4: A size write (`size_we` high, code on `size_code`) is used by every cycle that starts on a later clock. A cycle that starts on the same clock as the write is decoded with the previous size.
- R5: When `bus_hold` is high, `win_sel_n` is high on the next clock. This overrides a `cyc_start` on the same clock.
- R6: Inside a bus cycle, with no start, end or hold, `win_sel_n` does not change. A size write in this period has no effect on it.
- R7: `cyc_end` without `cyc_start` makes `win_sel_n` high on the next clock. `cyc_start` and `cyc_end` on the same clock start the new cycle.
- R8: After `bus_hold` falls, `win_sel_n` stays high until the next `cyc_start`.
- R9: For every size, the window base address and FFFFFh are inside the window, and the address one below the base is outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_addr | input | 20 | Physical address of the bus cycle |
| cyc_start | input | 1 | First clock of a bus cycle |
| cyc_end | input | 1 | Last clock of a bus cycle |
| bus_hold | input | 1 | Another master owns the bus |
| size_we | input | 1 | Write strobe for the size register |
| size_code | input | 2 | New window size code |
| win_sel_n | output | 1 | Registered active-low window select |

## Verification
Two things can happen on the same clock. A size write can coincide with a cycle start, and a bus-hold can coincide with a cycle start. For the first case, the bench raises `size_we` and `cyc_start` together. The address is chosen so that it lies outside the old 64 KB window but inside the new 512 KB one; the select must stay high for that cycle and go low on the next cycle to the same address. For the second case, the bench raises `bus_hold` together with a start to FFFF0h, and the select must stay high. A behavioural model checks every clock.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
   typedef enum logic [1:0] {
      SZ_64K  = 2'd0,
      SZ_128K = 2'd1,
      SZ_256K = 2'd2,
      SZ_512K = 2'd3
   } hrs_size_e;

   localparam int HRS_ADDR_W    = 20;
   localparam int HRS_SIZE_W    = 2;
   localparam int HRS_MIN_SHIFT = 16;
endpackage

// File: rtl/hrs_size_reg.sv
module hrs_size_reg #(
   parameter int SIZE_W     = hrs_pkg::HRS_SIZE_W,
   parameter int RESET_CODE = int'(hrs_pkg::SZ_64K)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SIZE_W-1:0] wr_code,
   output logic [SIZE_W-1:0] code_q
);
   localparam logic [SIZE_W-1:0] RST_VAL = SIZE_W'(RESET_CODE);

   if (RESET_CODE < 0 || RESET_CODE >= (1 << SIZE_W)) begin : g_bad_reset
      initial $error("hrs_size_reg: reset code out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     code_q <= RST_VAL;
      else if (wr_en) code_q <= wr_code;
   end

   assert_size_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> code_q == $past(wr_code));
   assert_size_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(code_q));
endmodule

// File: rtl/hrs_range_cmp.sv
module hrs_range_cmp #(
   parameter int ADDR_W    = hrs_pkg::HRS_ADDR_W,
   parameter int SIZE_W    = hrs_pkg::HRS_SIZE_W,
   parameter int MIN_SHIFT = hrs_pkg::HRS_MIN_SHIFT,
   parameter int CMP_STYLE = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] code,
   output logic              hit
);
   localparam int NSIZE = 1 << SIZE_W;
   localparam logic [ADDR_W:0] TOP = (ADDR_W+1)'(1) << ADDR_W;

   if (MIN_SHIFT + NSIZE > ADDR_W) begin : g_bad_geom
      initial $error("hrs_range_cmp: largest window exceeds half the space");
   end
   if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_style
      initial $error("hrs_range_cmp: CMP_STYLE must be 0 or 1");
   end

   logic [NSIZE-1:0] in_win;

   for (genvar k = 0; k < NSIZE; k++) begin : g_size
      if (CMP_STYLE == 0) begin : g_mask
         assign in_win[k] = &addr[ADDR_W-1:MIN_SHIFT+k];
      end else begin : g_mag
         localparam logic [ADDR_W:0] BASE_K =
            TOP - ((ADDR_W+1)'(1) << (MIN_SHIFT + k));
         assign in_win[k] = ({1'b0, addr} >= BASE_K);
      end
   end

   assign hit = in_win[code];
endmodule

// File: rtl/hrs_sel_gen.sv
module hrs_sel_gen #(
   parameter bit BOOT_ACTIVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic cyc_start,
   input  logic cyc_end,
   input  logic hold,
   output logic sel_n
);
   localparam logic RST_SEL_N = ~BOOT_ACTIVE;

   logic sel_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sel_n_q <= RST_SEL_N;
      else if (hold)       sel_n_q <= 1'b1;
      else if (cyc_start)  sel_n_q <= ~hit;
      else if (cyc_end)    sel_n_q <= 1'b1;
   end

   assign sel_n = sel_n_q;

   assert_hold_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> sel_n);
   assert_start_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !hold && hit) |=> !sel_n);
   assert_start_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !hold && !hit) |=> sel_n);
   assert_cycle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_start && !cyc_end && !hold) |=> $stable(sel_n));
   assert_end_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_end && !cyc_start) |=> sel_n);
endmodule

// File: rtl/hi_region_sel.sv
module hi_region_sel #(
   parameter int ADDR_W      = hrs_pkg::HRS_ADDR_W,
   parameter int SIZE_W      = hrs_pkg::HRS_SIZE_W,
   parameter int MIN_SHIFT   = hrs_pkg::HRS_MIN_SHIFT,
   parameter int RESET_CODE  = int'(hrs_pkg::SZ_64K),
   parameter int CMP_STYLE   = 0,
   parameter bit BOOT_ACTIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              cyc_start,
   input  logic              cyc_end,
   input  logic              bus_hold,
   input  logic              size_we,
   input  logic [SIZE_W-1:0] size_code,
   output logic              win_sel_n
);
   logic [SIZE_W-1:0] code_q;
   logic              hit;

   hrs_size_reg #(.SIZE_W(SIZE_W), .RESET_CODE(RESET_CODE)) u_size (
      .clk(clk), .rst_n(rst_n), .wr_en(size_we), .wr_code(size_code),
      .code_q(code_q)
   );

   hrs_range_cmp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MIN_SHIFT(MIN_SHIFT),
                   .CMP_STYLE(CMP_STYLE)) u_cmp (
      .addr(bus_addr), .code(code_q), .hit(hit)
   );

   hrs_sel_gen #(.BOOT_ACTIVE(BOOT_ACTIVE)) u_sel (
      .clk(clk), .rst_n(rst_n), .hit(hit), .cyc_start(cyc_start),
      .cyc_end(cyc_end), .hold(bus_hold), .sel_n(win_sel_n)
   );

   assert_hit_upper_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> bus_addr[ADDR_W-1]);
   assert_top_addr_hits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !bus_hold && (&bus_addr)) |=> !win_sel_n);
endmodule

// File: tb/sim_hi_region_sel.sv
module sim_hi_region_sel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        cyc_start = 1'b0;
   logic        cyc_end = 1'b0;
   logic        bus_hold = 1'b0;
   logic        size_we = 1'b0;
   logic [1:0]  size_code = 2'b00;
   logic        win_sel_n;

   always #4 clk = ~clk;

   hi_region_sel u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .cyc_start(cyc_start),
      .cyc_end(cyc_end), .bus_hold(bus_hold), .size_we(size_we),
      .size_code(size_code), .win_sel_n(win_sel_n)
   );

   int    total = 0;
   int    bad = 0;
   int    clk_cnt = 0;
   string cur_req = "R1";

   // behavioural reference
   int   m_size = 0;
   logic m_sel = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sel  <= 1'b0;
         m_size <= 0;
      end else begin
         if (bus_hold)
            m_sel <= 1'b1;
         else if (cyc_start)
            m_sel <= !(int'(bus_addr) >= (32'h100000 - (32'h10000 << m_size)));
         else if (cyc_end)
            m_sel <= 1'b1;
         if (size_we) m_size <= int'(size_code);
      end
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   always @(posedge clk) begin
      clk_cnt++;
      if (clk_cnt > 50000) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk);
      total++;
      if (win_sel_n !== m_sel) begin
         bad++;
         $display("FAIL %s model: actual=%b expected=%b", cur_req, win_sel_n, m_sel);
      end
   endtask

   task automatic expect_sel(string req, logic val);
      total++;
      if (win_sel_n !== val) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, win_sel_n, val);
      end
   endtask

   task automatic bus_cycle(logic [19:0] a);
      bus_addr = a; cyc_start = 1'b1;
      tick();
      cyc_start = 1'b0;
      tick(); tick();
      cyc_end = 1'b1;
      tick();
      cyc_end = 1'b0;
      tick();
   endtask

   task automatic write_size(logic [1:0] c);
      size_code = c; size_we = 1'b1;
      tick();
      size_we = 1'b0;
   endtask

   initial begin
      // R1: reset state
      tick(); tick();
      expect_sel("R1", 1'b0);
      rst_n = 1'b1;
      tick(); tick();
      expect_sel("R1", 1'b0);
      bus_cycle(20'hFFFF0);
      bus_addr = 20'hFFFF0; cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      expect_sel("R1", 1'b0);
      cyc_end = 1'b1; tick(); cyc_end = 1'b0; tick();

      // R2, R3, R9: every size, edges of the window
      for (int c = 0; c < 4; c++) begin
         int base;
         base = 32'h100000 - (32'h10000 << c);
         cur_req = "R2";
         write_size(c[1:0]);
         cur_req = "R9";
         bus_cycle(base[19:0]);
         bus_cycle(base[19:0] - 20'h1);
         bus_cycle(20'hFFFFF);
         cur_req = "R3";
         bus_cycle(20'h00000);
         bus_cycle(20'h80000);
      end

      // R4: write and start on the same clock
      cur_req = "R4";
      write_size(2'b00);
      bus_addr = 20'hE0000; cyc_start = 1'b1; size_code = 2'b11; size_we = 1'b1;
      tick();
      cyc_start = 1'b0; size_we = 1'b0;
      expect_sel("R4", 1'b1);
      cyc_end = 1'b1; tick(); cyc_end = 1'b0; tick();
      bus_addr = 20'hE0000; cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      expect_sel("R4", 1'b0);
      cyc_end = 1'b1; tick(); cyc_end = 1'b0; tick();

      // R6: size write inside a cycle changes nothing
      cur_req = "R6";
      bus_addr = 20'h90000; cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      size_code = 2'b00; size_we = 1'b1; tick(); size_we = 1'b0;
      tick(); tick();
      expect_sel("R6", 1'b0);
      cyc_end = 1'b1; tick(); cyc_end = 1'b0; tick();

      // R7: back-to-back cycles
      cur_req = "R7";
      bus_addr = 20'hFFFF0; cyc_start = 1'b1; tick(); cyc_start = 1'b0; tick();
      bus_addr = 20'h10000; cyc_start = 1'b1; cyc_end = 1'b1; tick();
      cyc_start = 1'b0; cyc_end = 1'b0;
      expect_sel("R7", 1'b1);
      bus_addr = 20'hF8000; cyc_start = 1'b1; cyc_end = 1'b1; tick();
      cyc_start = 1'b0; cyc_end = 1'b0;
      expect_sel("R7", 1'b0);
      cyc_end = 1'b1; tick(); cyc_end = 1'b0;
      expect_sel("R7", 1'b1);

      // R5: hold against start, and hold inside a cycle
      cur_req = "R5";
      bus_addr = 20'hFFFF0; cyc_start = 1'b1; bus_hold = 1'b1; tick();
      cyc_start = 1'b0;
      expect_sel("R5", 1'b1);
      bus_hold = 1'b0; tick();
      bus_addr = 20'hFFFF0; cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      expect_sel("R5", 1'b0);
      bus_hold = 1'b1; tick(); tick();
      expect_sel("R5", 1'b1);

      // R8: stays inactive after release
      cur_req = "R8";
      bus_hold = 1'b0;
      tick(); tick(); tick();
      expect_sel("R8", 1'b1);
      bus_cycle(20'hFFFF0);

      summary();
      $finish;
   end
endmodule